// File: doc/BRIEF.md
# Wide Register Byte Bridge

This block sits between an 8-bit register bus and a bank of 16-bit registers, such as counters, periods and compare values. Each 16-bit register takes two byte addresses. A single holding byte is shared by the whole bank, so a pair of byte accesses behaves as one atomic 16-bit access. On a read, the low byte comes from the live register. In the same cycle, the high byte is parked in the holding byte, so the following high-byte read returns a consistent snapshot. On a write, the low byte waits in the holding byte, and the high-byte write then commits all sixteen bits to the target register in one cycle.

The order is fixed: low byte first, then high byte. Because only one holding byte exists, software must not let a second two-step access run inside another one. An interleaved access overwrites the holding byte, and the interrupted access then completes with a wrong low byte, or a wrong high byte on the read path. The block keeps this behaviour on purpose, so that the effect of such interleaving can be observed.

Top module: `wide_reg_byte_bridge`

## Requirements
- R1: After reset, the read data output is 0x00, the holding byte is 0x00 and no write-enable bit is set.
- R2: Register i has its low byte at address 2i and its high byte at 2i+1. A read of the low byte (address bit 0 = 0) puts that register's live low byte on the read data output one cycle after the strobe. In the same cycle it loads the live high byte into the holding byte.
- R3: A read of the high byte (address bit 0 = 1) returns the holding byte one cycle after the strobe, not the live high byte. A low read followed by a high read therefore gives the value at the time of the low read.
- R4: A write to a low-byte address loads the bus data into the holding byte and asserts no write enable.
- R5: A write to a high-byte address asserts only write-enable bit i, in the same cycle as the write strobe. The write value is {bus data, holding byte}. The enable is a single-cycle pulse.
- R6: The holding byte is shared by all registers. A low read or low write to any register between the two halves of another access changes what that access completes with.
- R7: A high-byte read with no preceding low access returns whatever the holding byte last received (0x00 after reset).
- R8: An address whose register index is NUM_REGS or above reads as 0x00. Such an access leaves the holding byte unchanged and asserts no write enable.
- R9: When the read and write strobes are both high, the write is carried out. The read is ignored: the read data output and the read side effect on the holding byte are both suppressed.
- R10: The read data output holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, valid the cycle after the read strobe |
| liveVals | input | 16*NUM_REGS | Live register values, register i at bits [16i+15:16i] |
| wrData | output | 16 | 16-bit value to commit |
| wrEn | output | NUM_REGS | Per-register commit strobe |

## Verification
On every cycle, the assertions check the following:
- At most one commit strobe is active, and it appears only during a high-byte write.
- A low-byte write never commits.
- A low-byte read returns the live low byte on the next cycle.
- An out-of-range read yields zero.
- Read data holds when no read occurs.

The snapshot property, stale high reads and corruption through interleaving depend on the history of the holding byte. Only the bench's scenarios show these, by tracking that byte in a reference model across sequences in which the live values change between the two halves of an access.

// File: rtl/wrbb_pkg.sv
package wrbb_pkg;
  typedef struct packed {
    logic rdLow;
    logic rdHigh;
    logic rdMiss;
    logic wrLow;
    logic wrHigh;
  } busStrobes_t;
endpackage

// File: rtl/wrbb_ctrl.sv
module wrbb_ctrl
  import wrbb_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W = 2,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output busStrobes_t       strobes,
  output logic [IDX_W-1:0]  regIdx
);
  localparam logic [IDX_W:0] LAST_PLUS_ONE = (IDX_W+1)'(NUM_REGS);

  logic inRange;
  logic hiSel;
  logic rdOnly;

  assign regIdx  = busAddr[ADDR_W-1:1];
  assign hiSel   = busAddr[0];
  assign inRange = {1'b0, regIdx} < LAST_PLUS_ONE;
  // a write always wins over a read in the same cycle
  assign rdOnly  = busRd && !busWr;

  always_comb begin
    strobes        = '0;
    strobes.rdLow  = rdOnly && inRange && !hiSel;
    strobes.rdHigh = rdOnly && inRange && hiSel;
    strobes.rdMiss = rdOnly && !inRange;
    strobes.wrLow  = busWr && inRange && !hiSel;
    strobes.wrHigh = busWr && inRange && hiSel;
  end
endmodule

// File: rtl/wrbb_datapath.sv
module wrbb_datapath
  import wrbb_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobes_t           strobes,
  input  logic [IDX_W-1:0]      regIdx,
  input  logic [7:0]            busWdata,
  input  logic [16*NUM_REGS-1:0] liveVals,
  output logic [7:0]            busRdata,
  output logic [15:0]           wrData,
  output logic [NUM_REGS-1:0]   wrEn
);
  logic [15:0] liveArr [NUM_REGS];
  logic [15:0] livePick;
  logic [7:0]  holdByte;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_regs
    assign liveArr[g] = liveVals[16*g +: 16];
    assign wrEn[g]    = strobes.wrHigh && (regIdx == IDX_W'(g));
  end

  always_comb begin
    livePick = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regIdx == IDX_W'(i)) livePick = liveArr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      busRdata <= '0;
    end else begin
      if (strobes.rdLow) begin
        busRdata <= livePick[7:0];
        holdByte <= livePick[15:8];
      end
      if (strobes.rdHigh) busRdata <= holdByte;
      if (strobes.rdMiss) busRdata <= '0;
      if (strobes.wrLow)  holdByte <= busWdata;
    end
  end

  assign wrData = {busWdata, holdByte};
endmodule

// File: rtl/wide_reg_byte_bridge.sv
module wide_reg_byte_bridge
  import wrbb_pkg::*;
#(
  parameter int NUM_REGS = 3,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busRd,
  input  logic                   busWr,
  input  logic [7:0]             busWdata,
  output logic [7:0]             busRdata,
  input  logic [16*NUM_REGS-1:0] liveVals,
  output logic [15:0]            wrData,
  output logic [NUM_REGS-1:0]    wrEn
);
  busStrobes_t      strobes;
  logic [IDX_W-1:0] regIdx;

  wrbb_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .strobes(strobes), .regIdx(regIdx)
  );

  wrbb_datapath #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regIdx(regIdx),
    .busWdata(busWdata), .liveVals(liveVals), .busRdata(busRdata),
    .wrData(wrData), .wrEn(wrEn)
  );
endmodule

// File: rtl/wrbb_checker.sv
module wrbb_checker #(
  parameter int NUM_REGS = 3,
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busRd,
  input logic                   busWr,
  input logic [7:0]             busRdata,
  input logic [16*NUM_REGS-1:0] liveVals,
  input logic [NUM_REGS-1:0]    wrEn
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);
  logic [ADDR_W-1:0] idxExt;
  logic              okIdx;
  assign idxExt = {1'b0, busAddr[ADDR_W-1:1]};
  assign okIdx  = idxExt < LIMIT;

  // R5
  commit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEn));
  // R5
  commit_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn != '0) |-> (busWr && busAddr[0]));
  // R4
  low_write_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr[0]) |-> (wrEn == '0));
  // R8
  miss_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !okIdx |-> (wrEn == '0));
  // R2
  low_read_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && !busAddr[0] && okIdx) |=>
      busRdata == $past(liveVals[idxExt*16 +: 8]));
  // R8
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && !okIdx) |=> busRdata == 8'h00);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));
endmodule

bind wide_reg_byte_bridge wrbb_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busRdata(busRdata), .liveVals(liveVals), .wrEn(wrEn)
);

// File: tb/wide_reg_byte_bridge_test.sv
module wide_reg_byte_bridge_test;
  localparam int N = 3;
  logic clk = 0;
  logic rstN = 0;
  logic [2:0] busAddr = '0;
  logic busRd = 0, busWr = 0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [16*N-1:0] liveVals = '0;
  logic [15:0] wrData;
  logic [N-1:0] wrEn;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mTemp = '0, mRdata = '0;
  string prevTag = "R1";

  always #2 clk = ~clk;

  wide_reg_byte_bridge #(.NUM_REGS(N)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .liveVals(liveVals),
    .wrData(wrData), .wrEn(wrEn)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string opTag(bit rd, bit wr, logic [2:0] a);
    if (a[2:1] >= N) return "R8";
    if (rd && wr) return "R9";
    if (wr) return a[0] ? "R5" : "R4";
    if (rd) return a[0] ? "R3" : "R2";
    return "R10";
  endfunction

  task automatic step(string ctx, bit rd, bit wr, logic [2:0] a, logic [7:0] wd,
                      logic [16*N-1:0] live);
    int idx;
    logic [N-1:0] expEn;
    string t;
    @(negedge clk);
    check({prevTag, " rdata"}, 32'(busRdata), 32'(mRdata));
    busRd = rd; busWr = wr; busAddr = a; busWdata = wd; liveVals = live;
    #1;
    idx = int'(a[2:1]);
    t = {ctx, " ", opTag(rd, wr, a)};
    expEn = '0;
    if (wr && a[0] && idx < N) expEn[idx] = 1'b1;
    check({t, " wrEn"}, 32'(wrEn), 32'(expEn));
    if (expEn != '0) check({t, " wrData"}, 32'(wrData), 32'({wd, mTemp}));
    if (idx >= N) begin
      if (rd && !wr) mRdata = 8'h00;
    end else if (wr) begin
      if (!a[0]) mTemp = wd;
    end else if (rd) begin
      if (!a[0]) begin
        mRdata = live[16*idx +: 8];
        mTemp  = live[16*idx+8 +: 8];
      end else mRdata = mTemp;
    end
    prevTag = t;
  endtask

  initial begin
    #(200000*4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [16*N-1:0] lv;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R1: reset state
    check("R1 rdata", 32'(busRdata), 0);
    check("R1 wrEn", 32'(wrEn), 0);
    // R7: high read straight after reset yields zero holding byte
    lv = 48'hA1B2_C3D4_E5F6;
    step("R7", 1, 0, 3'd3, 8'h00, lv);
    step("R1", 0, 0, 3'd0, 8'h00, lv);
    // R3: snapshot survives a change of the live value
    step("R3", 1, 0, 3'd0, 8'h00, 48'h0000_0000_12AB);
    step("R3", 1, 0, 3'd1, 8'h00, 48'h0000_0000_34CD);
    // R4/R5: atomic write
    step("R4", 0, 1, 3'd2, 8'h5A, lv);
    step("R5", 0, 1, 3'd3, 8'hC3, lv);
    // R6: low write to reg1, low read of reg2 interleaves, high write to reg1
    step("R6", 0, 1, 3'd2, 8'h55, lv);
    step("R6", 1, 0, 3'd4, 8'h00, 48'h9F00_0000_0000);
    step("R6", 0, 1, 3'd3, 8'h66, lv);
    // R7: stale high read returns the last holding byte
    step("R7", 1, 0, 3'd5, 8'h00, lv);
    // R8: out of range
    step("R8", 1, 0, 3'd6, 8'h00, lv);
    step("R8", 0, 1, 3'd7, 8'h77, lv);
    step("R8", 1, 0, 3'd1, 8'h00, lv);
    // R9: both strobes
    step("R9", 1, 1, 3'd0, 8'h3C, lv);
    step("R9", 1, 1, 3'd1, 8'h4D, lv);
    // R10: idle cycles
    step("R10", 0, 0, 3'd0, 8'h00, lv);
    step("R10", 0, 0, 3'd0, 8'h00, lv);
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom % 6;
      for (int j = 0; j < 3; j++) lv[16*j +: 16] = 16'($urandom);
      step("rand", op inside {1, 2, 5}, op inside {3, 4, 5}, 3'($urandom), 8'($urandom), lv);
    end
    step("R10", 0, 0, 3'd0, 8'h00, lv);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule